// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit buses, A and B, and holds one storage register for each direction of transfer. Each bus is modelled as three separate signals: an input, an output and one output-enable bit. This replaces a true tri-state pin. An active-low drive enable and a direction input decide which bus, if any, is driven. A per-direction select input picks what the driven bus carries: either the live data from the opposite bus or the value held in that direction's register.

Each register has its own capture strobe. The strobe is sampled against the system clock. When the strobe was high at one clock edge and is low at the next edge, that next edge loads the register from its source bus. The new contents appear on the cycle after that edge. Capture works in every drive state. This includes capturing from a bus that the block is itself driving, and loading both registers in the same cycle.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The A-to-B register loads `a_in` at the clock edge where `strobe_ab` is sampled low after having been sampled high at the previous edge. The new value is visible from the following cycle.
- R2: The B-to-A register loads `b_in` at the clock edge where `strobe_ba` is sampled low after having been sampled high at the previous edge. The new value is visible from the following cycle.
- R3: Outside a detected falling strobe, a register keeps its value. Reset clears both registers and the strobe history to zero. A strobe that is held low from reset onward therefore loads nothing.
- R4: While `drive_en_n` is 1, both `a_oe` and `b_oe` are 0, and both `a_out` and `b_out` read 8'h00.
- R5: While `drive_en_n` is 0, `dir_a2b`=1 gives `b_oe`=1 and `a_oe`=0, and `dir_a2b`=0 gives `a_oe`=1 and `b_oe`=0. The enables follow their inputs in the same cycle.
- R6: `a_oe` and `b_oe` are never both 1.
- R7: While `b_oe` is 1, `sel_ab_stored`=0 puts `a_in` unchanged on `b_out` in the same cycle. `sel_ab_stored`=1 puts the A-to-B register on `b_out`.
- R8: While `a_oe` is 1, `sel_ba_stored`=0 puts `b_in` unchanged on `a_out` in the same cycle. `sel_ba_stored`=1 puts the B-to-A register on `a_out`.
- R9: Captures do not depend on enable, direction or select. Both registers can load at the same edge, and a register can load from the bus that is being driven at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en_n | input | 1 | Active-low enable for driving either bus |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab_stored | input | 1 | B output source: 0 live A, 1 stored A-to-B value |
| sel_ba_stored | input | 1 | A output source: 0 live B, 1 stored B-to-A value |
| strobe_ab | input | 1 | Capture strobe of the A-to-B register (falling edge loads) |
| strobe_ba | input | 1 | Capture strobe of the B-to-A register (falling edge loads) |
| a_in | input | 8 | Value present on bus A |
| a_out | output | 8 | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value present on bus B |
| b_out | output | 8 | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The two functions that can fall in the same cycle are a register capture and a live transfer that drives the same bus the capture reads from. A further case is two captures at once. The bench enables A-to-B live transfer and makes both strobes fall at the same edge. In that cycle it checks that `b_out` follows `a_in` unchanged. After the edge it switches each select to stored and confirms that each register holds the bus value present at that edge. It also checks that the drive settings in force at the time had no effect on either load.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;

    // Default bus width shared by the top and its submodules
    localparam int unsigned XCVR_WIDTH = 8;

    // Index of each transfer direction inside the per-direction vectors
    typedef enum logic {
        PATH_A2B = 1'b0,
        PATH_B2A = 1'b1
    } xfer_path_e;

    localparam int unsigned NUM_PATHS = 2;

endpackage

// File: rtl/xcvr_capture.sv
// One storage register with its own sampled falling-edge strobe.
module xcvr_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] data_q
);

    typedef struct packed {
        logic         strobe_seen;
        logic [W-1:0] held;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic       fall_hit;

    always_comb begin
        state_d             = state_q;
        fall_hit            = state_q.strobe_seen && !strobe;
        state_d.strobe_seen = strobe;
        if (fall_hit) begin
            state_d.held = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign data_q = state_q.held;

    // R1 and R2: a detected fall loads the source value seen at that edge
    assert_load_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.strobe_seen && !strobe) |=> (data_q == $past(data_in)));

    // R3: with no detected fall the stored value does not move
    assert_hold_no_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q.strobe_seen && !strobe) |=> $stable(data_q));

endmodule

// File: rtl/xcvr_drive_ctrl.sv
// Decodes enable and direction into the two bus drive enables.
module xcvr_drive_ctrl (
    input  logic drive_en_n,
    input  logic dir_a2b,
    output logic drive_a,
    output logic drive_b
);

    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        if (!drive_en_n) begin
            if (dir_a2b) begin
                drive_b = 1'b1;
            end else begin
                drive_a = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xcvr_path_mux.sv
// Chooses live or stored data for one direction and quiets it when not driving.
module xcvr_path_mux #(
    parameter int unsigned W = 8
) (
    input  logic         use_stored,
    input  logic         drive,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out
);

    logic [W-1:0] pick;

    always_comb begin
        pick = use_stored ? stored : live;
        out  = drive ? pick : '0;
    end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import dual_reg_xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drive_en_n,
    input  logic         dir_a2b,
    input  logic         sel_ab_stored,
    input  logic         sel_ba_stored,
    input  logic         strobe_ab,
    input  logic         strobe_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [NUM_PATHS-1:0]        strobe_vec;
    logic [NUM_PATHS-1:0]        sel_vec;
    logic [NUM_PATHS-1:0]        drive_vec;
    logic [NUM_PATHS-1:0][W-1:0] src_vec;
    logic [NUM_PATHS-1:0][W-1:0] stored_vec;
    logic [NUM_PATHS-1:0][W-1:0] out_vec;
    logic                        drive_a;
    logic                        drive_b;

    always_comb begin
        strobe_vec[PATH_A2B] = strobe_ab;
        strobe_vec[PATH_B2A] = strobe_ba;
        sel_vec[PATH_A2B]    = sel_ab_stored;
        sel_vec[PATH_B2A]    = sel_ba_stored;
        src_vec[PATH_A2B]    = a_in;
        src_vec[PATH_B2A]    = b_in;
        drive_vec[PATH_A2B]  = drive_b;
        drive_vec[PATH_B2A]  = drive_a;
    end

    xcvr_drive_ctrl u_drive (
        .drive_en_n (drive_en_n),
        .dir_a2b    (dir_a2b),
        .drive_a    (drive_a),
        .drive_b    (drive_b)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        xcvr_capture #(.W(W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (strobe_vec[p]),
            .data_in (src_vec[p]),
            .data_q  (stored_vec[p])
        );

        xcvr_path_mux #(.W(W)) u_mux (
            .use_stored (sel_vec[p]),
            .drive      (drive_vec[p]),
            .live       (src_vec[p]),
            .stored     (stored_vec[p]),
            .out        (out_vec[p])
        );
    end

    assign b_out = out_vec[PATH_A2B];
    assign a_out = out_vec[PATH_B2A];
    assign b_oe  = drive_b;
    assign a_oe  = drive_a;

    // R6: never drive both buses
    assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));

    // R4: isolated outputs read zero
    assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    // R5: direction picks the driven bus
    assert_dir_sets_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en_n |-> (b_oe == dir_a2b && a_oe == !dir_a2b));

    // R7: live A reaches B unchanged
    assert_live_a2b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !sel_ab_stored) |-> (b_out == a_in));

    // R8: live B reaches A unchanged
    assert_live_b2a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !sel_ba_stored) |-> (a_out == b_in));

endmodule

// File: tb/dual_reg_xcvr_bench.sv
module dual_reg_xcvr_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         drive_en_n = 1'b1;
    logic         dir_a2b = 1'b0;
    logic         sel_ab_stored = 1'b0;
    logic         sel_ba_stored = 1'b0;
    logic         strobe_ab = 1'b0;
    logic         strobe_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // Bench-side model of the two stored values
    logic [W-1:0] m_ab = '0;
    logic [W-1:0] m_ba = '0;

    always #2 clk = ~clk;

    dual_reg_xcvr #(.W(W)) u_dual_reg_xcvr (
        .clk           (clk),
        .rst_n         (rst_n),
        .drive_en_n    (drive_en_n),
        .dir_a2b       (dir_a2b),
        .sel_ab_stored (sel_ab_stored),
        .sel_ba_stored (sel_ba_stored),
        .strobe_ab     (strobe_ab),
        .strobe_ba     (strobe_ba),
        .a_in          (a_in),
        .a_out         (a_out),
        .a_oe          (a_oe),
        .b_in          (b_in),
        .b_out         (b_out),
        .b_oe          (b_oe)
    );

    // {drive_en_n, dir_a2b, sel_ab, sel_ba, expected a_oe, expected b_oe}
    localparam logic [5:0] VEC [0:15] = '{
        6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
        6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
        6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
        6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
    };

    task automatic check(input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Model-based comparison of all four outputs
    task automatic check_outputs(input string req);
        logic         e_aoe;
        logic         e_boe;
        logic [W-1:0] e_a;
        logic [W-1:0] e_b;
        e_aoe = !drive_en_n && !dir_a2b;
        e_boe = !drive_en_n && dir_a2b;
        e_b   = e_boe ? (sel_ab_stored ? m_ab : a_in) : '0;
        e_a   = e_aoe ? (sel_ba_stored ? m_ba : b_in) : '0;
        check(req, "a_oe",  {7'd0, a_oe}, {7'd0, e_aoe});
        check(req, "b_oe",  {7'd0, b_oe}, {7'd0, e_boe});
        check(req, "a_out", a_out, e_a);
        check(req, "b_out", b_out, e_b);
    endtask

    // Raise both selected strobes, then drop them with the given bus values
    task automatic capture(input bit do_ab, input bit do_ba,
                           input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        if (do_ab) strobe_ab = 1'b1;
        if (do_ba) strobe_ba = 1'b1;
        @(negedge clk);
        a_in = av;
        b_in = bv;
        strobe_ab = 1'b0;
        strobe_ba = 1'b0;
        @(negedge clk);
        if (do_ab) m_ab = av;
        if (do_ba) m_ba = bv;
    endtask

    task automatic show_stored;
        drive_en_n = 1'b0;
        sel_ab_stored = 1'b1;
        sel_ba_stored = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state: isolated, quiet outputs
        #1 check("R4", "a_oe after reset", {7'd0, a_oe}, 8'h00);
        check("R4", "b_out after reset", b_out, 8'h00);

        // R3: strobes held low from reset load nothing
        a_in = 8'h5A; b_in = 8'hA5;
        repeat (3) @(negedge clk);
        show_stored; dir_a2b = 1'b1;
        #1 check("R3", "stored A after reset", b_out, 8'h00);
        dir_a2b = 1'b0;
        #1 check("R3", "stored B after reset", a_out, 8'h00);
        drive_en_n = 1'b1;

        // R1, R2: individual captures
        capture(1'b1, 1'b0, 8'h3C, 8'h77);
        show_stored; dir_a2b = 1'b1;
        #1 check("R1", "A-to-B load", b_out, 8'h3C);
        dir_a2b = 1'b0;
        #1 check("R2", "B-to-A untouched", a_out, 8'h00);
        drive_en_n = 1'b1;
        capture(1'b0, 1'b1, 8'h11, 8'hC3);
        show_stored; dir_a2b = 1'b0;
        #1 check("R2", "B-to-A load", a_out, 8'hC3);
        dir_a2b = 1'b1;
        #1 check("R1", "A-to-B kept", b_out, 8'h3C);

        // R3: low strobe with changing buses does not reload
        @(negedge clk);
        a_in = 8'hFF; b_in = 8'h00;
        repeat (2) @(negedge clk);
        #1 check("R3", "hold A-to-B", b_out, 8'h3C);
        dir_a2b = 1'b0;
        #1 check("R3", "hold B-to-A", a_out, 8'hC3);
        drive_en_n = 1'b1;

        // R4..R8: every enable/direction/select combination
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            {drive_en_n, dir_a2b, sel_ab_stored, sel_ba_stored} = VEC[i][5:2];
            a_in = 8'(8'hA5 ^ (i * 8'h11));
            b_in = 8'(8'h3C + (i * 8'h1D));
            #1;
            check("R5", "table a_oe", {7'd0, a_oe}, {7'd0, VEC[i][1]});
            check("R6", "table b_oe", {7'd0, b_oe}, {7'd0, VEC[i][0]});
            check_outputs("R7/R8 table");
        end

        // R9: both captures at the same edge while A drives B live
        @(negedge clk);
        drive_en_n = 1'b0; dir_a2b = 1'b1;
        sel_ab_stored = 1'b0; sel_ba_stored = 1'b0;
        strobe_ab = 1'b1; strobe_ba = 1'b1;
        @(negedge clk);
        a_in = 8'h96; b_in = 8'h69;
        strobe_ab = 1'b0; strobe_ba = 1'b0;
        #1 check("R9", "live A during capture", b_out, 8'h96);
        check("R6", "single driver during capture", {6'd0, a_oe, b_oe}, 8'h01);
        @(negedge clk);
        m_ab = 8'h96; m_ba = 8'h69;
        a_in = 8'h00; b_in = 8'h00;
        sel_ab_stored = 1'b1;
        #1 check("R9", "dual capture A-to-B", b_out, 8'h96);
        dir_a2b = 1'b0; sel_ba_stored = 1'b1;
        #1 check("R9", "dual capture B-to-A", a_out, 8'h69);

        // R7, R8: non-inverting with extreme patterns
        sel_ab_stored = 1'b0; sel_ba_stored = 1'b0;
        b_in = 8'h81;
        #1 check("R8", "live B walk", a_out, 8'h81);
        dir_a2b = 1'b1; a_in = 8'hFF;
        #1 check("R7", "live A ones", b_out, 8'hFF);

        // R3: reset clears registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ab = '0; m_ba = '0;
        sel_ab_stored = 1'b1;
        #1 check("R3", "reset clears A-to-B", b_out, 8'h00);
        dir_a2b = 1'b0; sel_ba_stored = 1'b1;
        #1 check("R3", "reset clears B-to-A", a_out, 8'h00);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule